// File: doc/BRIEF.md
# SAR Converter Digital Interface

This block is the digital side of a 12-bit successive-approximation converter. It turns two active-low control lines into conversion starts, times each conversion, keeps the completed result and presents it on a parallel bus or a serial line. Analog tracking and the bit search are outside the block. A conversion is modelled as a fixed number of system clock cycles. The sample input is captured in the cycle the conversion starts.

The host drives `cs_n` and `rd_cnv`. A conversion starts when their OR goes low, so whichever line falls last starts it. Holding `cs_n` low and `rd_cnv` high reads the bus. The bus always shows the newest completed result. While idle that is result n. While conversion n runs it is result n-1. The bus is carried as a value plus a drive enable, and the pad cell makes the high-impedance state from them.

Serial output has two clocking choices. In the internal choice, the previous result is shifted out one bit per system clock once a conversion starts. In the external choice, a read start loads the shifter and each rising edge of the external data clock advances it. `fmt_sb` picks the coding: straight binary, or the same word with its top bit inverted (two's complement).

Top module: `sar_adc_digital_if`

## Requirements
- R1: A conversion starts only when `cs_n` and `rd_cnv` were both low at the previous clock edge, and the combined level was high at the edge before that. `rdy` falls one cycle after the edge that samples both low.
- R2: `rdy` stays low for exactly CONV_CYCLES cycles. A command that goes low and high again during a conversion changes neither its length nor its result.
- R3: The result holds `sample_in` as it was at the start edge. Later changes to `sample_in` during the conversion do not affect it.
- R4: `pdata_oe` is high exactly when `cs_n` is low and `rd_cnv` is high. When `pdata_oe` is low, `pdata` and `pdata_bad` are 0, including during the start of a conversion.
- R5: During a read, `pdata` shows the last completed result. While a conversion runs, this is the result of the conversion before it. After the conversion ends, it is the new result.
- R6: If both control lines are still low when `rdy` returns high, `rdy` stays high for one cycle and then a new conversion starts. That conversion captures `sample_in` at its own start, and its result is shown with `pdata_bad` = 1. A normal conversion clears the flag.
- R7: With `fmt_sb` = 1 the output word equals the raw sample: 000 is the lowest input, 800 is midscale, FFF is full scale.
- R8: With `fmt_sb` = 0 the output word is the raw sample with bit 11 inverted: midscale is 000, positive full scale is 7FF, negative full scale is 800.
- R9: With `ext_clk_sel` = 0, the start of a conversion loads the previously completed coded result into the shifter. `sdata` then shows bit 11 down to bit 0, one bit per clock, starting one cycle after the start edge, with `sbit_valid` high for those 12 cycles and low afterwards.
- R10: With `ext_clk_sel` = 1, the rising edge of `pdata_oe` loads the coded result into the shifter, with bit 11 on `sdata`. Each rising edge of `ext_dclk`, after a two-stage synchronizer, moves to the next lower bit. After 12 edges `sbit_valid` goes low.
- R11: Reading the bus, repeatedly or for a long time, never changes the stored result and never starts a conversion.
- R12: After reset, `rdy` = 1, `sbit_valid` = 0, `sdata` = 0, and the stored result is 0 with its invalid flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_cnv | input | 1 | High selects read, low requests a conversion |
| fmt_sb | input | 1 | 1 = straight binary, 0 = two's complement |
| ext_clk_sel | input | 1 | 1 = serial shift on external data clock, 0 = on system clock |
| ext_dclk | input | 1 | External serial data clock, asynchronous |
| sample_in | input | 12 | Digitized sample captured at conversion start |
| rdy | output | 1 | High when idle, low during a conversion |
| pdata | output | 12 | Parallel bus value, 0 when not driven |
| pdata_oe | output | 1 | Parallel bus drive enable |
| pdata_bad | output | 1 | Presented result came from a conversion with no acquisition |
| sdata | output | 1 | Serial data, MSB first |
| sbit_valid | output | 1 | A serial bit is present on `sdata` |

## Verification
A wrong start decision shows up on `rdy` one cycle after the edge where both control lines are sampled low. A wrong countdown shows up as a low period of the wrong length at the next idle transition. A result register that moves outside a completed conversion is seen at the next read, either as a changed `pdata` or as a wrongly set `pdata_bad`. Errors in the shifter appear as a wrong bit on `sdata` within one system clock in the internal choice, or three clocks after an external clock edge in the external choice.

// File: rtl/sar_if_pkg.sv
package sar_if_pkg;

  // Conversion sequencer phase
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_CONV = 1'b1
  } conv_phase_e;

  // Serial shifter clocking choice
  typedef enum logic [0:0] {
    SCLK_SYS = 1'b0,
    SCLK_EXT = 1'b1
  } ser_clk_e;

endpackage

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_if_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_cnv,
  output logic rdy,
  output logic start_evt,
  output logic start_b2b,
  output logic done_evt
);

  localparam int unsigned CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(CONV_CYCLES - 1);

  conv_phase_e   phase;
  logic [CW-1:0] cnt;
  logic          cmd_low;
  logic          cmd_low_q;
  logic          just_done;

  // The two control lines act as one level: low only when both are low
  assign cmd_low   = ~(cs_n | rd_cnv);
  assign start_evt = (phase == PH_IDLE) && cmd_low && (!cmd_low_q || just_done);
  assign start_b2b = start_evt && just_done;
  assign done_evt  = (phase == PH_CONV) && (cnt == '0);
  assign rdy       = (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      cmd_low_q <= 1'b1;
      just_done <= 1'b0;
    end else begin
      cmd_low_q <= cmd_low;
      just_done <= done_evt;
      if (start_evt) begin
        phase <= PH_CONV;
        cnt   <= CNT_LOAD;
      end else if (done_evt) begin
        phase <= PH_IDLE;
      end else if (phase == PH_CONV) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(!cs_n && !rd_cnv)); // R1

  AST_CONV_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && cnt != '0) |=> (phase == PH_CONV && cnt == $past(cnt) - CW'(1))); // R2

  AST_CONV_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> rdy); // R2

  AST_B2B_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && just_done && cmd_low) |=> !rdy); // R6

endmodule

// File: rtl/sar_result_store.sv
module sar_result_store #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic          start_b2b,
  input  logic          done_evt,
  input  logic [DW-1:0] sample_in,
  output logic [DW-1:0] res_word,
  output logic          res_bad
);

  // In-flight conversion (n) and last completed result
  logic [DW-1:0] pend_word;
  logic          pend_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_word <= '0;
      pend_bad  <= 1'b0;
      res_word  <= '0;
      res_bad   <= 1'b0;
    end else begin
      if (start_evt) begin
        pend_word <= sample_in;
        pend_bad  <= start_b2b;
      end
      if (done_evt) begin
        res_word <= pend_word;
        res_bad  <= pend_bad;
      end
    end
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> ($stable(res_word) && $stable(res_bad))); // R11

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(pend_word)); // R3

endmodule

// File: rtl/sar_out_coder.sv
module sar_out_coder #(
  parameter int unsigned DW = 12
) (
  input  logic          fmt_sb,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] code
);

  // Offset-binary raw value; two's complement differs only in the top bit
  function automatic logic [DW-1:0] apply_fmt(input logic [DW-1:0] v, input logic sb);
    logic [DW-1:0] flip;
    flip = {1'b1, {(DW-1){1'b0}}};
    return sb ? v : (v ^ flip);
  endfunction

  assign code = apply_fmt(raw, fmt_sb);

endmodule

// File: rtl/sar_ser_shift.sv
module sar_ser_shift
  import sar_if_pkg::*;
#(
  parameter int unsigned DW          = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ser_clk_e      clk_mode,
  input  logic          ext_dclk,
  input  logic          load_evt,
  input  logic [DW-1:0] load_word,
  output logic          sdata,
  output logic          sbit_valid
);

  localparam int unsigned BW = $clog2(DW + 1);
  localparam logic [BW-1:0] BITS_FULL = BW'(DW);

  logic [SYNC_STAGES-1:0] dclk_sync;
  logic                   dclk_last;
  logic                   dclk_rise;
  logic                   shift_en;
  logic [DW-1:0]          sh;
  logic [BW-1:0]          bits_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_sync <= '0;
      dclk_last <= 1'b0;
    end else begin
      dclk_sync <= {dclk_sync[SYNC_STAGES-2:0], ext_dclk};
      dclk_last <= dclk_sync[SYNC_STAGES-1];
    end
  end

  assign dclk_rise = dclk_sync[SYNC_STAGES-1] & ~dclk_last;
  assign shift_en  = (clk_mode == SCLK_EXT) ? dclk_rise : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      bits_left <= '0;
    end else if (load_evt) begin
      sh        <= load_word;
      bits_left <= BITS_FULL;
    end else if (bits_left != '0 && shift_en) begin
      sh        <= {sh[DW-2:0], 1'b0};
      bits_left <= bits_left - BW'(1);
    end
  end

  assign sbit_valid = (bits_left != '0);
  assign sdata      = sh[DW-1] & sbit_valid;

  AST_SER_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (sbit_valid && sdata == $past(load_word[DW-1]))); // R9

  AST_SER_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_mode == SCLK_EXT && !dclk_rise && !load_evt) |=> $stable(bits_left)); // R10

endmodule

// File: rtl/sar_adc_digital_if.sv
module sar_adc_digital_if
  import sar_if_pkg::*;
#(
  parameter int unsigned DW          = 12,
  parameter int unsigned CONV_CYCLES = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_cnv,
  input  logic          fmt_sb,
  input  logic          ext_clk_sel,
  input  logic          ext_dclk,
  input  logic [DW-1:0] sample_in,
  output logic          rdy,
  output logic [DW-1:0] pdata,
  output logic          pdata_oe,
  output logic          pdata_bad,
  output logic          sdata,
  output logic          sbit_valid
);

  logic          start_evt;
  logic          start_b2b;
  logic          done_evt;
  logic [DW-1:0] res_word;
  logic          res_bad;
  logic [DW-1:0] res_code;
  logic          read_on;
  logic          read_q;
  logic          rd_start;
  logic          ser_load;
  ser_clk_e      clk_mode;

  sar_conv_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_cnv    (rd_cnv),
    .rdy       (rdy),
    .start_evt (start_evt),
    .start_b2b (start_b2b),
    .done_evt  (done_evt)
  );

  sar_result_store #(.DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .start_b2b (start_b2b),
    .done_evt  (done_evt),
    .sample_in (sample_in),
    .res_word  (res_word),
    .res_bad   (res_bad)
  );

  sar_out_coder #(.DW(DW)) u_coder (
    .fmt_sb (fmt_sb),
    .raw    (res_word),
    .code   (res_code)
  );

  // Read window and its rising edge
  assign read_on  = ~cs_n & rd_cnv;
  assign rd_start = read_on & ~read_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) read_q <= 1'b0;
    else        read_q <= read_on;
  end

  assign clk_mode = ext_clk_sel ? SCLK_EXT : SCLK_SYS;
  assign ser_load = (clk_mode == SCLK_EXT) ? rd_start : start_evt;

  sar_ser_shift #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_mode   (clk_mode),
    .ext_dclk   (ext_dclk),
    .load_evt   (ser_load),
    .load_word  (res_code),
    .sdata      (sdata),
    .sbit_valid (sbit_valid)
  );

  assign pdata_oe  = read_on;
  assign pdata     = read_on ? res_code : '0;
  assign pdata_bad = read_on & res_bad;

  AST_BUS_OFF_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(!pdata_oe)); // R4

endmodule

// File: tb/sar_adc_digital_if_test.sv
`timescale 1ns/1ps
module sar_adc_digital_if_test;

  localparam int CONV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_cnv = 1'b1;
  logic        fmt_sb = 1'b1;
  logic        ext_clk_sel = 1'b0;
  logic        ext_dclk = 1'b0;
  logic [11:0] sample_in = '0;
  logic        rdy;
  logic [11:0] pdata;
  logic        pdata_oe;
  logic        pdata_bad;
  logic        sdata;
  logic        sbit_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sar_adc_digital_if #(.DW(12), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cnv(rd_cnv), .fmt_sb(fmt_sb),
    .ext_clk_sel(ext_clk_sel), .ext_dclk(ext_dclk), .sample_in(sample_in),
    .rdy(rdy), .pdata(pdata), .pdata_oe(pdata_oe), .pdata_bad(pdata_bad),
    .sdata(sdata), .sbit_valid(sbit_valid)
  );

  // Coding table: raw sample, format, expected word
  localparam int NV = 8;
  localparam logic [11:0] T_SAMP [NV] = '{12'h000, 12'h000, 12'h800, 12'h800,
                                         12'hFFF, 12'hFFF, 12'h7FF, 12'hA5C};
  localparam logic        T_FMT  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [11:0] T_EXP  [NV] = '{12'h000, 12'h800, 12'h800, 12'h000,
                                         12'hFFF, 12'h7FF, 12'hFFF, 12'h25C};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Start a conversion, release the lines, count the cycles rdy stays low
  task automatic convert(input logic [11:0] s, output int busy_len);
    @(negedge clk); sample_in = s; cs_n = 1'b0; rd_cnv = 1'b0;
    @(negedge clk); cs_n = 1'b1; rd_cnv = 1'b1; sample_in = ~s;
    busy_len = 0;
    while (!rdy && busy_len < 1000) begin
      busy_len++;
      @(negedge clk);
    end
  endtask

  task automatic read_bus(input logic fmt, output logic [11:0] v, output logic bad);
    @(negedge clk); fmt_sb = fmt; cs_n = 1'b0; rd_cnv = 1'b1;
    #1; v = pdata; bad = pdata_bad;
    @(negedge clk); cs_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int len;
    logic [11:0] v;
    logic b;
    logic [11:0] w;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 rdy", rdy, 1);
    chk("R12 sbit_valid", sbit_valid, 0);
    chk("R12 sdata", sdata, 0);
    chk("R4 oe idle", pdata_oe, 0);
    chk("R4 bus zero idle", pdata, 0);
    read_bus(1'b1, v, b);
    chk("R12 result zero", v, 12'h000);
    chk("R12 bad clear", b, 0);

    // R7 / R8 coding table, one conversion per entry
    for (int i = 0; i < NV; i++) begin
      convert(T_SAMP[i], len);
      read_bus(T_FMT[i], v, b);
      chk(T_FMT[i] ? "R7 straight binary" : "R8 twos complement", v, T_EXP[i]);
    end

    // R1 / R2 / R3 conversion length and capture
    convert(12'h3C1, len);
    chk("R2 conversion length", len, CONV);
    read_bus(1'b1, v, b);
    chk("R3 sample latched at start", v, 12'h3C1);

    // R1: no start while one line high
    @(negedge clk); cs_n = 1'b0; rd_cnv = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 no start while reading", rdy, 1);
    rd_cnv = 1'b0; sample_in = 12'h0F0;
    @(negedge clk);
    chk("R1 start when last line falls", rdy, 0);
    chk("R4 bus off at start", pdata_oe, 0);
    cs_n = 1'b1; rd_cnv = 1'b1;
    while (!rdy) @(negedge clk);

    // R2 command during conversion ignored
    @(negedge clk); sample_in = 12'h5A5; cs_n = 1'b0; rd_cnv = 1'b0;
    @(negedge clk); cs_n = 1'b1; rd_cnv = 1'b1; sample_in = 12'h111;
    len = 1;
    @(negedge clk); cs_n = 1'b0; rd_cnv = 1'b0; len++;
    @(negedge clk); cs_n = 1'b1; rd_cnv = 1'b1; len++;
    while (!rdy && len < 1000) begin @(negedge clk); if (!rdy) len++; end
    chk("R2 length with extra command", len, CONV);
    read_bus(1'b1, v, b);
    chk("R2 result unchanged by extra command", v, 12'h5A5);

    // R5 previous result while converting, new result after
    @(negedge clk); sample_in = 12'hB0B; cs_n = 1'b0; rd_cnv = 1'b0;
    @(negedge clk); cs_n = 1'b1; rd_cnv = 1'b1;
    @(negedge clk); cs_n = 1'b0; rd_cnv = 1'b1; fmt_sb = 1'b1; #1;
    chk("R5 busy during read", rdy, 0);
    chk("R4 oe during read", pdata_oe, 1);
    chk("R5 n-1 while converting", pdata, 12'h5A5);
    @(negedge clk); cs_n = 1'b1;
    while (!rdy) @(negedge clk);
    read_bus(1'b1, v, b);
    chk("R5 n after done", v, 12'hB0B);

    // R11 repeated reads leave everything unchanged
    @(negedge clk); cs_n = 1'b0; rd_cnv = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11 long read value", pdata, 12'hB0B);
    chk("R11 long read no start", rdy, 1);
    cs_n = 1'b1;
    read_bus(1'b1, v, b);
    chk("R11 value after reads", v, 12'hB0B);

    // R6 back-to-back conversion
    @(negedge clk); sample_in = 12'h123; cs_n = 1'b0; rd_cnv = 1'b0;
    @(negedge clk); sample_in = 12'h456;
    repeat (CONV) @(negedge clk);
    chk("R6 rdy high for one cycle", rdy, 1);
    @(negedge clk);
    chk("R6 restart without command edge", rdy, 0);
    cs_n = 1'b1; rd_cnv = 1'b1; sample_in = 12'h000;
    while (!rdy) @(negedge clk);
    read_bus(1'b1, v, b);
    chk("R6 restart sample", v, 12'h456);
    chk("R6 invalid flag set", b, 1);
    convert(12'h789, len);
    read_bus(1'b1, v, b);
    chk("R6 flag cleared by normal conversion", b, 0);

    // R9 internal serial: previous result 789, two's complement -> F89
    @(negedge clk); ext_clk_sel = 1'b0; fmt_sb = 1'b0;
    sample_in = 12'h222; cs_n = 1'b0; rd_cnv = 1'b0;
    w = '0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 0) begin cs_n = 1'b1; rd_cnv = 1'b1; end
      if (!sbit_valid) w = 12'hEEE;
      w = {w[10:0], sdata};
    end
    chk("R9 internal serial word", w, 12'hF89);
    @(negedge clk);
    chk("R9 valid low after 12 bits", sbit_valid, 0);
    while (!rdy) @(negedge clk);

    // R10 external serial: stored 222, straight binary
    @(negedge clk); ext_clk_sel = 1'b1; fmt_sb = 1'b1; cs_n = 1'b0; rd_cnv = 1'b1;
    @(negedge clk);
    chk("R10 valid after read start", sbit_valid, 1);
    w = {11'd0, sdata};
    repeat (5) @(negedge clk);
    chk("R10 no shift without clock edge", sdata, 0);
    for (int k = 1; k < 12; k++) begin
      ext_dclk = 1'b1; repeat (4) @(negedge clk);
      ext_dclk = 1'b0; repeat (2) @(negedge clk);
      w = {w[10:0], sdata};
    end
    chk("R10 external serial word", w, 12'h222);
    ext_dclk = 1'b1; repeat (4) @(negedge clk);
    ext_dclk = 1'b0; repeat (2) @(negedge clk);
    chk("R10 valid low after 12 edges", sbit_valid, 0);
    cs_n = 1'b1; ext_clk_sel = 1'b0;
    @(negedge clk);
    chk("R4 bus zero after read", pdata, 0);

    finish_run();
  end

endmodule